// File: doc/BRIEF.md
# Lookahead Integer ALU with Overflow Trap

This block is the purely combinational arithmetic and logic unit of a simple load/store integer datapath. Two operands and a three-bit operation code go in. The unit returns a result word together with a zero flag, the adder's carry out and a request line for a signed-overflow exception. The pipeline routes that request to its exception logic; vectoring to a handler is not part of this block.

A single adder serves addition, subtraction and signed compare. For subtraction and compare, the second operand passes through an XOR inverter and the adder's carry-in is forced to one. The adder is built from fixed-size lookahead groups. Each group forms its own internal carries from per-bit generate and propagate terms. A second lookahead network, built from the same logic, spans the groups and forms the carry into each group.

A per-operation trap enable chooses between the signed behaviour, where overflow requests an exception, and the unsigned-style variants, where overflow is ignored. Because the block holds no state, it has no handshake. Its inputs are sampled by whatever register stage surrounds it, and its outputs are valid in the same cycle.

Top module: `lookahead_alu`

## Requirements
- R1: With op_sel = 3'b000, result is the bitwise AND of opa and opb, carry_out is 0 and ovf_trap is 0.
- R2: With op_sel = 3'b001, result is the bitwise OR of opa and opb, carry_out is 0 and ovf_trap is 0.
- R3: With op_sel = 3'b010, result is (opa + opb) modulo 2^WIDTH. carry_out is the unsigned carry out of bit WIDTH-1.
- R4: With op_sel = 3'b110, result is (opa - opb) modulo 2^WIDTH. carry_out is the carry of opa + ~opb + 1, which is 1 exactly when opa >= opb as unsigned numbers.
- R5: For op_sel = 3'b010 with trap_en = 1, ovf_trap is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it. When the signs differ, ovf_trap is never raised.
- R6: For op_sel = 3'b110 with trap_en = 1, ovf_trap is 1 exactly when the operands' sign bits differ and the difference's sign bit differs from that of opa.
- R7: When trap_en = 0, ovf_trap is 0 for every operation and operand pair, including pairs that overflow signed. The result and carry_out are unchanged by trap_en.
- R8: With op_sel = 3'b111, result is 1 when opa < opb as signed two's complement numbers, and 0 otherwise. This holds even when opa - opb overflows. ovf_trap stays 0, and carry_out is the subtraction carry of R4.
- R9: Every op_sel value not listed above gives result 0, carry_out 0 and ovf_trap 0.
- R10: zero_flag is 1 exactly when every bit of result is 0, whatever the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand (subtrahend for subtract and compare) |
| op_sel | input | 3 | Operation code: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed less-than |
| trap_en | input | 1 | 1 lets signed overflow of add/subtract raise ovf_trap; 0 for unsigned variants |
| result | output | WIDTH | Selected result word |
| zero_flag | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Adder carry out for add, subtract and compare; 0 otherwise |
| ovf_trap | output | 1 | Signed-overflow exception request |

## Verification
The bench builds the block with its defaults, WIDTH = 32 and GROUP = 4. That gives eight four-bit lookahead groups under an eight-input second-level network. With this shape, a carry that enters at bit 0 and crosses every group boundary (all-ones plus one) can be tested, as can a carry generated exactly at a group edge such as bit 3 into bit 4. The sign boundaries 0x7FFFFFFF and 0x80000000 then sit in the top group. There the overflow trap and the overflow-corrected compare can be driven through both the trapping and the non-trapping paths.

// File: rtl/alu_pkg.sv
package alu_pkg;

  parameter int ALU_W   = 32;
  parameter int CLA_GRP = 4;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

endpackage

// File: rtl/cla_carry_net.sv
// Lookahead carry network: every carry is a flat sum of products of the
// generate/propagate terms below it plus the incoming carry.
module cla_carry_net #(
  parameter int N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         cin,
  output logic [N-1:0] c,
  output logic         blk_g,
  output logic         blk_p
);

  always_comb begin
    logic acc;
    logic term;
    c[0] = cin;
    for (int i = 1; i < N; i++) begin
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        term = g[j];
        for (int k = j + 1; k < i; k++) term = term & p[k];
        acc = acc | term;
      end
      term = cin;
      for (int k = 0; k < i; k++) term = term & p[k];
      c[i] = acc | term;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = g[j];
      for (int k = j + 1; k < N; k++) term = term & p[k];
      acc = acc | term;
    end
    blk_g = acc;
    blk_p = &p;
  end

endmodule

// File: rtl/cla_slice.sv
// One lookahead group: local carries, sum bits, and group generate/propagate.
module cla_slice #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         grp_g,
  output logic         grp_p
);

  logic [N-1:0] gen;
  logic [N-1:0] prop;
  logic [N-1:0] carry;

  assign gen  = a & b;
  assign prop = a | b;

  cla_carry_net #(.N(N)) u_net (
    .g     (gen),
    .p     (prop),
    .cin   (cin),
    .c     (carry),
    .blk_g (grp_g),
    .blk_p (grp_p)
  );

  assign sum = a ^ b ^ carry;

endmodule

// File: rtl/cla_adder.sv
// Two-level lookahead adder built from GROUP-bit slices.
module cla_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NGRP = WIDTH / GROUP;

  logic [NGRP-1:0] gg;
  logic [NGRP-1:0] gp;
  logic [NGRP-1:0] gc;
  logic            top_g;
  logic            top_p;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_slice
    cla_slice #(.N(GROUP)) u_slice (
      .a     (a[gi*GROUP +: GROUP]),
      .b     (b[gi*GROUP +: GROUP]),
      .cin   (gc[gi]),
      .sum   (sum[gi*GROUP +: GROUP]),
      .grp_g (gg[gi]),
      .grp_p (gp[gi])
    );
  end

  cla_carry_net #(.N(NGRP)) u_grp_net (
    .g     (gg),
    .p     (gp),
    .cin   (cin),
    .c     (gc),
    .blk_g (top_g),
    .blk_p (top_p)
  );

  assign cout = top_g | (top_p & cin);

  // R3: the lookahead sum and carry agree with plain binary addition
  always_comb begin
    a_r3_sum_matches: assert ({cout, sum} ==
      ({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)))
      else $error("R3 lookahead sum mismatch");
  end

endmodule

// File: rtl/alu_result_mux.sv
// Output selection by operation code.
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] sum,
  input  logic             less,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result
);

  always_comb begin
    unique case (op_sel)
      OP_AND:  result = opa & opb;
      OP_OR:   result = opa | opb;
      OP_ADD,
      OP_SUB:  result = sum;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, less};
      default: result = '0;
    endcase
  end

  // R8: a compare only ever yields 0 or 1
  always_comb begin
    if (op_sel == OP_SLT)
      a_r8_slt_single_bit: assert (result[WIDTH-1:1] == '0)
        else $error("R8 compare result wider than one bit");
  end

endmodule

// File: rtl/lookahead_alu.sv
module lookahead_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = ALU_W,
  parameter int GROUP = CLA_GRP
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       op_sel,
  input  logic             trap_en,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             carry_out,
  output logic             ovf_trap
);

  localparam int MSB = WIDTH - 1;

  logic             is_add;
  logic             is_sub;
  logic             is_slt;
  logic             invert;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             add_cout;
  logic             ovf_raw;
  logic             less;

  assign is_add = (op_sel == OP_ADD);
  assign is_sub = (op_sel == OP_SUB);
  assign is_slt = (op_sel == OP_SLT);
  assign invert = is_sub | is_slt;
  assign b_eff  = opb ^ {WIDTH{invert}};

  cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_adder (
    .a    (opa),
    .b    (b_eff),
    .cin  (invert),
    .sum  (sum),
    .cout (add_cout)
  );

  // Signed overflow: addends of equal sign producing a sum of the other sign.
  assign ovf_raw = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
  assign less    = sum[MSB] ^ ovf_raw;

  alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .opa    (opa),
    .opb    (opb),
    .sum    (sum),
    .less   (less),
    .op_sel (op_sel),
    .result (result)
  );

  assign zero_flag = (result == '0);
  assign carry_out = (is_add | is_sub | is_slt) & add_cout;
  assign ovf_trap  = trap_en & ovf_raw & (is_add | is_sub);

  always_comb begin
    // R7: the unsigned variants never request an exception
    if (!trap_en)
      a_r7_no_trap_unsigned: assert (!ovf_trap)
        else $error("R7 trap raised with trap_en low");
    // R5: adding operands of different sign cannot overflow
    if (is_add && (opa[MSB] != opb[MSB]))
      a_r5_mixed_sign_add: assert (!ovf_trap)
        else $error("R5 trap on mixed-sign add");
    // R9: undefined codes give a quiet zero
    if (!(is_add | is_sub | is_slt) && (op_sel != OP_AND) && (op_sel != OP_OR))
      a_r9_unused_quiet: assert ((result == '0) && !carry_out && !ovf_trap)
        else $error("R9 unused code not quiet");
    // R8: compare never traps
    if (is_slt)
      a_r8_slt_no_trap: assert (!ovf_trap)
        else $error("R8 trap raised by compare");
  end

endmodule

// File: tb/lookahead_alu_test.sv
module lookahead_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [2:0]  op_sel = 3'b000;
  logic        trap_en = 1'b0;
  logic [31:0] result;
  logic        zero_flag;
  logic        carry_out;
  logic        ovf_trap;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lookahead_alu uut (
    .opa       (opa),
    .opb       (opb),
    .op_sel    (op_sel),
    .trap_en   (trap_en),
    .result    (result),
    .zero_flag (zero_flag),
    .carry_out (carry_out),
    .ovf_trap  (ovf_trap)
  );

  // Model from the requirements: {trap, carry, zero, result}
  function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] op, input logic te);
    logic [32:0] s;
    logic [31:0] r;
    logic c;
    logic v;
    r = '0; c = 1'b0; v = 1'b0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin
        s = {1'b0, a} + {1'b0, b};
        r = s[31:0]; c = s[32];
        v = te && (a[31] == b[31]) && (s[31] != a[31]);
      end
      3'b110: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = s[31:0]; c = s[32];
        v = te && (a[31] != b[31]) && (s[31] != a[31]);
      end
      3'b111: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        c = s[32];
        r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      end
      default: r = '0;
    endcase
    return {v, c, (r == 32'd0), r};
  endfunction

  task automatic apply_check(input string req, input logic [31:0] a, input logic [31:0] b,
                             input logic [2:0] op, input logic te);
    logic [34:0] exp;
    logic [34:0] act;
    @(posedge clk);
    opa = a; opb = b; op_sel = op; trap_en = te;
    @(negedge clk);
    exp = model(a, b, op, te);
    act = {ovf_trap, carry_out, zero_flag, result};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h op=%b te=%b actual trap/c/z/res=%b/%b/%b/%h expected %b/%b/%b/%h",
               req, a, b, op, te, act[34], act[33], act[32], act[31:0],
               exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic t_reset_state();
    apply_check("R10 idle zero", 32'h0, 32'h0, 3'b000, 1'b0);
  endtask

  task automatic t_logic_ops();
    apply_check("R1 and", 32'hF0F0_1234, 32'h0FF0_FF00, 3'b000, 1'b1);
    apply_check("R1 and zero", 32'hAAAA_AAAA, 32'h5555_5555, 3'b000, 1'b1);
    apply_check("R2 or", 32'hA5A5_0000, 32'h0000_5A5A, 3'b001, 1'b1);
    apply_check("R2 or zero", 32'h0, 32'h0, 3'b001, 1'b1);
  endtask

  task automatic t_add();
    apply_check("R3 add simple", 32'd2, 32'd7, 3'b010, 1'b1);
    apply_check("R3 add group edge", 32'h0000_000F, 32'h0000_0001, 3'b010, 1'b1);
    apply_check("R3 add full carry", 32'hFFFF_FFFF, 32'h0000_0001, 3'b010, 1'b1);
    apply_check("R3 add carry", 32'h8000_0000, 32'h8000_0000, 3'b010, 1'b0);
  endtask

  task automatic t_sub();
    apply_check("R4 sub", 32'd7, 32'd6, 3'b110, 1'b1);
    apply_check("R4 sub borrow", 32'd6, 32'd7, 3'b110, 1'b1);
    apply_check("R4 sub equal", 32'h1234_5678, 32'h1234_5678, 3'b110, 1'b1);
  endtask

  task automatic t_trap_add();
    apply_check("R5 pos+pos", 32'h7FFF_FFFF, 32'h0000_0001, 3'b010, 1'b1);
    apply_check("R5 neg+neg", 32'h8000_0000, 32'hFFFF_FFFF, 3'b010, 1'b1);
    apply_check("R5 mixed signs", 32'h7FFF_FFFF, 32'h8000_0000, 3'b010, 1'b1);
  endtask

  task automatic t_trap_sub();
    apply_check("R6 pos-neg", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, 1'b1);
    apply_check("R6 neg-pos", 32'h8000_0000, 32'h0000_0001, 3'b110, 1'b1);
    apply_check("R6 same signs", 32'h8000_0000, 32'h8000_0001, 3'b110, 1'b1);
  endtask

  task automatic t_unsigned();
    apply_check("R7 addu overflow", 32'h7FFF_FFFF, 32'h0000_0001, 3'b010, 1'b0);
    apply_check("R7 subu overflow", 32'h8000_0000, 32'h0000_0001, 3'b110, 1'b0);
  endtask

  task automatic t_slt();
    apply_check("R8 less", 32'hFFFF_FFFD, 32'd2, 3'b111, 1'b1);
    apply_check("R8 not less", 32'd2, 32'hFFFF_FFFD, 3'b111, 1'b1);
    apply_check("R8 overflow min<1", 32'h8000_0000, 32'd1, 3'b111, 1'b1);
    apply_check("R8 overflow max<min", 32'h7FFF_FFFF, 32'h8000_0000, 3'b111, 1'b1);
    apply_check("R8 equal", 32'd5, 32'd5, 3'b111, 1'b1);
  endtask

  task automatic t_unused();
    apply_check("R9 code 011", 32'h7FFF_FFFF, 32'h1, 3'b011, 1'b1);
    apply_check("R9 code 100", 32'hFFFF_FFFF, 32'h1, 3'b100, 1'b1);
    apply_check("R9 code 101", 32'h8000_0000, 32'h1, 3'b101, 1'b1);
  endtask

  task automatic t_sweep();
    logic [31:0] x;
    logic [2:0] ops [5];
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
    x = 32'h1357_9BDF;
    // Mixed operands across R1 R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      a = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      b = (i % 7 == 0) ? a : x;
      apply_check("R3-sweep", a, b, ops[i % 5], x[0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_logic_ops();
    t_add();
    t_sub();
    t_trap_add();
    t_trap_sub();
    t_unsigned();
    t_slt();
    t_unused();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule